// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel NOR-style flash and turns bus write cycles into array operations. Each write arrives as a one-cycle strobe with an address and a command byte. The decoder follows the multi-cycle unlock patterns. It emits a single-cycle start pulse, together with an operation code, the final address and the final data, to a separate array engine. The engine reports back through a busy flag.

Three launches are supported: word program, whole-array erase and single-block erase. A running block erase can be suspended and later resumed. A shortcut mode drops the unlock cycles from programming. Protection comes from two places: a write-protect pin that guards the whole-array erase, and one protect bit per block. Any write that does not fit the expected step is silently dropped. A write that arrives while the engine is busy is also dropped, except for the suspend command.

The block field is the top `BLK_W` address bits. The unlock addresses are compared on the offset inside the block, which is the remaining low bits.

Top module: `fcs_cmd_decoder`

## Requirements
- R1: After reset, and after a reset that interrupts a partly written sequence, no start pulse is issued until a complete new sequence has been written.
- R2: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `op_start` for one cycle, in the cycle after the sixth strobe, with `op_kind` = 2 (whole-array erase).
- R3: The four writes AAh@555h, 55h@2AAh, A0h@555h, then D@A launch a program: `op_kind` = 1, with `op_addr` = A and `op_data` = D.
- R4: A write whose address or data does not match the expected step returns the decoder to idle. That write does not count as the first write of a new sequence.
- R5: While `busy` is high every write is ignored, and the sequence position is not advanced. The one exception is the R8 suspend command.
- R6: A whole-array erase is discarded when `wp_n` is low, or when any bit of `blk_prot` is set.
- R7: Five unlock writes followed by 30h at an address launch `op_kind` = 3 (block erase) for that address's block. The launch is discarded if that block's `blk_prot` bit is set.
- R8: B0h at any address, written while busy with a block erase that is not yet suspended, gives `op_kind` = 4 (suspend). Later, 30h at any address written from idle outside shortcut mode gives `op_kind` = 5 (resume).
- R9: AAh@555h, 55h@2AAh, 20h@555h enters shortcut mode. In that mode, A0h followed by D@A programs (`op_kind` = 1). The pair 90h then 00h leaves the mode.
- R10: In shortcut mode, erase commands (80h then any byte), suspend (B0h) and resume (30h) are all ignored. A resume is honoured only after the mode has been left.
- R11: While an erase is suspended, a program into the suspended block is rejected and programs into other blocks are accepted. This holds both in and out of shortcut mode. Whole-array and block erases are rejected while suspended.
- R12: A program into a block whose `blk_prot` bit is set is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | 16 | Write address; the top 3 bits select the block |
| wr_data | input | 8 | Write command/data byte |
| wp_n | input | 1 | Write-protect pin, low protects against whole-array erase |
| blk_prot | input | 8 | Per-block protect bits, 1 = protected |
| busy | input | 1 | Array engine busy |
| op_start | output | 1 | One-cycle launch pulse |
| op_kind | output | 3 | Operation code: 1 program, 2 whole erase, 3 block erase, 4 suspend, 5 resume |
| op_addr | output | 16 | Address of the launching write |
| op_data | output | 8 | Data of the launching write |

## Verification
The command decoding is exercised with clean sequences for each launch type, which separates the operation codes and the captured address and data. Broken sequences then repeat a first byte or present later steps without a start, which separates "return to idle" from "restart the sequence". The protection patterns vary the pin and a single block bit. They show which launches depend on the pin and which depend on the target block. A suspend session mixes programs to the suspended block and to other blocks, both in and out of shortcut mode, and so tells the per-block suspend rule apart from a blanket rejection.

// File: rtl/fcs_pkg.sv
// Package: shared codes and state types for the flash command decoder.
// Assumes byte-wide command data and unlock offsets that fit in 12 bits.
package fcs_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_CHIP   = 3'd2,
        OP_BLK    = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5
    } op_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_U1,
        S_U2,
        S_PROG,
        S_E3,
        S_E4,
        S_E5,
        S_BIDLE,
        S_BPROG,
        S_BERA,
        S_BEXIT
    } seq_st_e;

    localparam logic [7:0]  CMD_KEY1     = 8'hAA;
    localparam logic [7:0]  CMD_KEY2     = 8'h55;
    localparam logic [7:0]  CMD_PROG     = 8'hA0;
    localparam logic [7:0]  CMD_ERASE    = 8'h80;
    localparam logic [7:0]  CMD_WHOLE    = 8'h10;
    localparam logic [7:0]  CMD_BLOCK    = 8'h30;
    localparam logic [7:0]  CMD_SHORT    = 8'h20;
    localparam logic [7:0]  CMD_SUSP     = 8'hB0;
    localparam logic [7:0]  CMD_RESUME   = 8'h30;
    localparam logic [7:0]  CMD_LEAVE1   = 8'h90;
    localparam logic [7:0]  CMD_LEAVE2   = 8'h00;

    localparam logic [11:0] OFS_KEY1     = 12'h555;
    localparam logic [11:0] OFS_KEY2     = 12'h2AA;

endpackage

// File: rtl/fcs_addr_dec.sv
// Address decoder: splits a write address into block index and in-block
// offset, flags the two unlock offsets and looks up protection/suspend.
// Assumes ADDR_W - BLK_W >= 12 so the unlock offsets fit.
module fcs_addr_dec
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 3
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [(1<<BLK_W)-1:0]  blk_prot,
    input  logic                   susp,
    input  logic [BLK_W-1:0]       susp_blk,
    output logic                   hit_a,
    output logic                   hit_b,
    output logic [BLK_W-1:0]       blk,
    output logic                   blk_locked,
    output logic                   blk_in_susp,
    output logic                   any_locked
);
    localparam int LOW_W = ADDR_W - BLK_W;

    // Offset compare against the two unlock addresses.
    always_comb begin
        hit_a = (addr[LOW_W-1:0] == LOW_W'(OFS_KEY1));
        hit_b = (addr[LOW_W-1:0] == LOW_W'(OFS_KEY2));
    end

    // Block index and per-block status lookup.
    always_comb begin
        blk         = addr[ADDR_W-1 -: BLK_W];
        blk_locked  = blk_prot[blk];
        blk_in_susp = susp && (blk == susp_blk);
        any_locked  = |blk_prot;
    end

endmodule

// File: rtl/fcs_susp_trk.sv
// Suspend tracker: remembers whether the last erase-type launch was a block
// erase, which block it targeted, and whether it is currently suspended.
// Assumes launches arrive as single-cycle pulses from the sequencer.
module fcs_susp_trk
    import fcs_pkg::*;
#(
    parameter int BLK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  op_kind_e          launch_kind,
    input  logic [BLK_W-1:0]  launch_blk,
    output logic              susp,
    output logic [BLK_W-1:0]  susp_blk,
    output logic              ers_active
);
    logic [BLK_W-1:0] ers_blk;

    // Track the running block erase and its suspend status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp       <= 1'b0;
            susp_blk   <= '0;
            ers_blk    <= '0;
            ers_active <= 1'b0;
        end else if (launch) begin
            case (launch_kind)
                OP_BLK: begin
                    ers_blk    <= launch_blk;
                    ers_active <= 1'b1;
                end
                OP_PROG, OP_CHIP: ers_active <= 1'b0;
                OP_SUSP: begin
                    susp     <= 1'b1;
                    susp_blk <= ers_blk;
                end
                OP_RESUME: begin
                    susp       <= 1'b0;
                    ers_active <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // A suspend must target a block erase in progress (R8).
    p_susp_needs_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        launch && launch_kind == OP_SUSP |-> ers_active && !susp);

    // Resume only from the suspended state (R8).
    p_resume_needs_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        launch && launch_kind == OP_RESUME |-> susp);

    // No erase launch while an erase is suspended (R11).
    p_no_erase_in_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        launch && (launch_kind == OP_CHIP || launch_kind == OP_BLK) |-> !susp);

endmodule

// File: rtl/fcs_seq.sv
// Command sequencer: steps through the unlock cycles, the shortcut mode and
// the busy/suspend rules, and registers one launch pulse per accepted command.
// Assumes wr_stb is a clean one-cycle pulse per bus write.
module fcs_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              hit_a,
    input  logic              hit_b,
    input  logic [BLK_W-1:0]  blk,
    input  logic              blk_locked,
    input  logic              blk_in_susp,
    input  logic              any_locked,
    input  logic              susp,
    input  logic              ers_active,
    output logic              op_start,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [BLK_W-1:0]  op_blk
);
    seq_st_e  st, st_nxt;
    logic     go;
    op_kind_e kind;
    logic     in_short;

    // Shortcut-mode membership of the current state.
    always_comb begin
        in_short = (st == S_BIDLE) || (st == S_BPROG) ||
                   (st == S_BERA)  || (st == S_BEXIT);
    end

    // Next-state and launch decision for one write strobe.
    always_comb begin
        st_nxt = st;
        go     = 1'b0;
        kind   = OP_NONE;
        if (wr_stb) begin
            if (busy) begin
                if (wr_data == CMD_SUSP && ers_active && !susp && !in_short) begin
                    go   = 1'b1;
                    kind = OP_SUSP;
                end
            end else begin
                case (st)
                    S_IDLE: begin
                        if (wr_data == CMD_KEY1 && hit_a) begin
                            st_nxt = S_U1;
                        end else if (wr_data == CMD_RESUME && susp) begin
                            go   = 1'b1;
                            kind = OP_RESUME;
                        end
                    end
                    S_U1: st_nxt = (wr_data == CMD_KEY2 && hit_b) ? S_U2 : S_IDLE;
                    S_U2: begin
                        st_nxt = S_IDLE;
                        if (hit_a) begin
                            if (wr_data == CMD_PROG)       st_nxt = S_PROG;
                            else if (wr_data == CMD_ERASE) st_nxt = S_E3;
                            else if (wr_data == CMD_SHORT) st_nxt = S_BIDLE;
                        end
                    end
                    S_PROG: begin
                        st_nxt = S_IDLE;
                        if (!blk_locked && !blk_in_susp) begin
                            go   = 1'b1;
                            kind = OP_PROG;
                        end
                    end
                    S_E3: st_nxt = (wr_data == CMD_KEY1 && hit_a) ? S_E4 : S_IDLE;
                    S_E4: st_nxt = (wr_data == CMD_KEY2 && hit_b) ? S_E5 : S_IDLE;
                    S_E5: begin
                        st_nxt = S_IDLE;
                        if (wr_data == CMD_WHOLE && hit_a) begin
                            if (wp_n && !any_locked && !susp) begin
                                go   = 1'b1;
                                kind = OP_CHIP;
                            end
                        end else if (wr_data == CMD_BLOCK) begin
                            if (!blk_locked && !susp) begin
                                go   = 1'b1;
                                kind = OP_BLK;
                            end
                        end
                    end
                    S_BIDLE: begin
                        if (wr_data == CMD_PROG)        st_nxt = S_BPROG;
                        else if (wr_data == CMD_ERASE)  st_nxt = S_BERA;
                        else if (wr_data == CMD_LEAVE1) st_nxt = S_BEXIT;
                    end
                    S_BPROG: begin
                        st_nxt = S_BIDLE;
                        if (!blk_locked && !blk_in_susp) begin
                            go   = 1'b1;
                            kind = OP_PROG;
                        end
                    end
                    S_BERA:  st_nxt = S_BIDLE;
                    S_BEXIT: st_nxt = (wr_data == CMD_LEAVE2) ? S_IDLE : S_BIDLE;
                    default: st_nxt = S_IDLE;
                endcase
            end
        end
    end

    // Sequence position register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

    // Launch pulse and operation capture toward the array engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
            op_blk   <= '0;
        end else begin
            op_start <= go;
            op_kind  <= kind;
            if (go) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
                op_blk  <= blk;
            end
        end
    end

    // Every launch follows a strobe (R2).
    p_start_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(wr_stb));

    // While busy only a suspend may launch (R5).
    p_busy_only_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && $past(busy) |-> op_kind == OP_SUSP);

    // Whole-array erase respects the pin and every block bit (R6).
    p_whole_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && op_kind == OP_CHIP |-> $past(wp_n) && !$past(any_locked));

    // Shortcut mode launches nothing but programs (R10).
    p_short_prog_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && $past(in_short) |-> op_kind == OP_PROG);

    // No program into the suspended block (R11).
    p_prog_not_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && op_kind == OP_PROG |-> !$past(blk_in_susp));

    // No program or block erase into a protected block (R12, R7).
    p_prog_unlocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        op_start && (op_kind == OP_PROG || op_kind == OP_BLK) |-> !$past(blk_locked));

endmodule

// File: rtl/fcs_cmd_decoder.sv
// Top: device-side flash write-command decoder. Wires the address decoder,
// the sequencer and the suspend tracker; outputs one launch per command.
// Assumes the array engine raises busy within a cycle of a launch.
module fcs_cmd_decoder
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  wp_n,
    input  logic [(1<<BLK_W)-1:0] blk_prot,
    input  logic                  busy,
    output logic                  op_start,
    output logic [2:0]            op_kind,
    output logic [ADDR_W-1:0]     op_addr,
    output logic [7:0]            op_data
);
    logic             hit_a, hit_b, blk_locked, blk_in_susp, any_locked;
    logic [BLK_W-1:0] blk, susp_blk, op_blk;
    logic             susp, ers_active;
    op_kind_e         kind_w;

    fcs_addr_dec #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
        .addr        (wr_addr),
        .blk_prot    (blk_prot),
        .susp        (susp),
        .susp_blk    (susp_blk),
        .hit_a       (hit_a),
        .hit_b       (hit_b),
        .blk         (blk),
        .blk_locked  (blk_locked),
        .blk_in_susp (blk_in_susp),
        .any_locked  (any_locked)
    );

    fcs_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wp_n        (wp_n),
        .busy        (busy),
        .hit_a       (hit_a),
        .hit_b       (hit_b),
        .blk         (blk),
        .blk_locked  (blk_locked),
        .blk_in_susp (blk_in_susp),
        .any_locked  (any_locked),
        .susp        (susp),
        .ers_active  (ers_active),
        .op_start    (op_start),
        .op_kind     (kind_w),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .op_blk      (op_blk)
    );

    fcs_susp_trk #(.BLK_W(BLK_W)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (op_start),
        .launch_kind (kind_w),
        .launch_blk  (op_blk),
        .susp        (susp),
        .susp_blk    (susp_blk),
        .ers_active  (ers_active)
    );

    // Expose the operation code as plain bits.
    always_comb op_kind = kind_w;

endmodule

// File: tb/sim_fcs_cmd_decoder.sv
module sim_fcs_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wp_n = 1'b1;
    logic [7:0]  blk_prot = '0;
    logic        busy = 1'b0;
    logic        op_start;
    logic [2:0]  op_kind;
    logic [15:0] op_addr;
    logic [7:0]  op_data;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    fcs_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wp_n(wp_n), .blk_prot(blk_prot), .busy(busy),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
    );

    // {addr, data, expect start, expect kind}
    localparam int NV = 34;
    localparam logic [27:0] VEC [NV] = '{
        {16'h0555, 8'hAA, 1'b0, 3'd0},  // R3 program
        {16'h02AA, 8'h55, 1'b0, 3'd0},
        {16'h0555, 8'hA0, 1'b0, 3'd0},
        {16'h2345, 8'h5A, 1'b1, 3'd1},
        {16'h0555, 8'hAA, 1'b0, 3'd0},  // R2 whole erase
        {16'h02AA, 8'h55, 1'b0, 3'd0},
        {16'h0555, 8'h80, 1'b0, 3'd0},
        {16'h0555, 8'hAA, 1'b0, 3'd0},
        {16'h02AA, 8'h55, 1'b0, 3'd0},
        {16'h0555, 8'h10, 1'b1, 3'd2},
        {16'h0555, 8'hAA, 1'b0, 3'd0},  // R4 mismatch, no restart
        {16'h0555, 8'hAA, 1'b0, 3'd0},
        {16'h02AA, 8'h55, 1'b0, 3'd0},
        {16'h0555, 8'hA0, 1'b0, 3'd0},
        {16'h4000, 8'h11, 1'b0, 3'd0},
        {16'h0555, 8'hAA, 1'b0, 3'd0},  // R7 block erase
        {16'h02AA, 8'h55, 1'b0, 3'd0},
        {16'h0555, 8'h80, 1'b0, 3'd0},
        {16'h0555, 8'hAA, 1'b0, 3'd0},
        {16'h02AA, 8'h55, 1'b0, 3'd0},
        {16'h6000, 8'h30, 1'b1, 3'd3},
        {16'h0555, 8'hAA, 1'b0, 3'd0},  // R9 shortcut entry
        {16'h02AA, 8'h55, 1'b0, 3'd0},
        {16'h0555, 8'h20, 1'b0, 3'd0},
        {16'h1234, 8'hA0, 1'b0, 3'd0},
        {16'h8888, 8'h77, 1'b1, 3'd1},
        {16'h0000, 8'hB0, 1'b0, 3'd0},  // R10 ignored in shortcut
        {16'h0000, 8'h30, 1'b0, 3'd0},
        {16'h0000, 8'h80, 1'b0, 3'd0},
        {16'h0555, 8'h10, 1'b0, 3'd0},
        {16'h0000, 8'h90, 1'b0, 3'd0},  // R9 leave
        {16'h0000, 8'h00, 1'b0, 3'd0},
        {16'h0555, 8'hA0, 1'b0, 3'd0},  // standard idle again
        {16'hA000, 8'h12, 1'b0, 3'd0}
    };

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic chk(input logic st_exp, input logic [2:0] k_exp, input string tag);
        nchk++;
        if (op_start !== st_exp || (st_exp && op_kind !== k_exp)) begin
            nfail++;
            $display("FAIL %s: start=%b kind=%0d expected start=%b kind=%0d",
                     tag, op_start, op_kind, st_exp, k_exp);
        end
    endtask

    task automatic chk_ad(input logic [15:0] a, input logic [7:0] d, input string tag);
        nchk++;
        if (op_addr !== a || op_data !== d) begin
            nfail++;
            $display("FAIL %s: addr=%h data=%h expected addr=%h data=%h",
                     tag, op_addr, op_data, a, d);
        end
    endtask

    task automatic unlock();
        wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] d);
        unlock(); wr(16'h0555, 8'hA0); wr(a, d);
    endtask

    task automatic erase_pre();
        unlock(); wr(16'h0555, 8'h80); unlock();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(1'b0, 3'd0, "R1 reset");
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][27:12], VEC[i][11:4]);
            chk(VEC[i][3], VEC[i][2:0], $sformatf("table[%0d]", i));
            if (VEC[i][3]) chk_ad(VEC[i][27:12], VEC[i][11:4], $sformatf("R3 table[%0d]", i));
        end

        // R1 reset mid-sequence
        unlock();
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        wr(16'h0555, 8'hA0); wr(16'h2000, 8'h44);
        chk(1'b0, 3'd0, "R1 reset mid-sequence");

        // R5 busy ignores commands
        erase_pre(); wr(16'h0555, 8'h10);
        chk(1'b1, 3'd2, "R2 whole erase");
        busy = 1'b1;
        wr(16'h0000, 8'hB0);
        chk(1'b0, 3'd0, "R5 suspend of whole erase");
        prog(16'h2345, 8'h5A);
        chk(1'b0, 3'd0, "R5 program while busy");
        busy = 1'b0;
        wr(16'h2345, 8'h5A);
        chk(1'b0, 3'd0, "R5 sequence not advanced");

        // R6 protection of whole erase
        wp_n = 1'b0;
        erase_pre(); wr(16'h0555, 8'h10);
        chk(1'b0, 3'd0, "R6 pin low");
        wp_n = 1'b1; blk_prot = 8'h80;
        erase_pre(); wr(16'h0555, 8'h10);
        chk(1'b0, 3'd0, "R6 block bit set");
        prog(16'hE010, 8'h21);
        chk(1'b0, 3'd0, "R12 program protected block");
        erase_pre(); wr(16'hE000, 8'h30);
        chk(1'b0, 3'd0, "R7 erase protected block");
        prog(16'h0010, 8'h22);
        chk(1'b1, 3'd1, "R12 program unprotected block");
        blk_prot = 8'h00;

        // R8 / R11 suspend session
        erase_pre(); wr(16'h6000, 8'h30);
        chk(1'b1, 3'd3, "R7 block erase");
        busy = 1'b1;
        wr(16'h0000, 8'hB0);
        chk(1'b1, 3'd4, "R8 suspend");
        busy = 1'b0;
        prog(16'h6100, 8'h11);
        chk(1'b0, 3'd0, "R11 program suspended block");
        prog(16'h2100, 8'h12);
        chk(1'b1, 3'd1, "R11 program other block");
        erase_pre(); wr(16'h0555, 8'h10);
        chk(1'b0, 3'd0, "R11 whole erase while suspended");
        erase_pre(); wr(16'h4000, 8'h30);
        chk(1'b0, 3'd0, "R11 block erase while suspended");
        unlock(); wr(16'h0555, 8'h20);
        wr(16'h0000, 8'hA0); wr(16'h6200, 8'h13);
        chk(1'b0, 3'd0, "R11 shortcut program suspended block");
        wr(16'h0000, 8'hA0); wr(16'hA200, 8'h14);
        chk(1'b1, 3'd1, "R11 shortcut program other block");
        wr(16'h0000, 8'h30);
        chk(1'b0, 3'd0, "R10 resume in shortcut");
        wr(16'h0000, 8'h90); wr(16'h0000, 8'h00);
        wr(16'h0000, 8'h30);
        chk(1'b1, 3'd5, "R8 resume after leaving");
        prog(16'h6100, 8'h15);
        chk(1'b1, 3'd1, "R8 program after resume");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule